// File: doc/BRIEF.md
# Vsync-Latched Window Shadow Register Bank

This block holds the double-buffered configuration of a multi-window display pipeline. Software writes the active-side registers through a simple write port whenever it likes. The working copy that the pixel pipeline consumes, called the shadow side, changes only on a vsync cycle. So a frame is never built from a half-written configuration.

Each window has a protect bit. While that bit is set, vsync skips the window. Software can set protect, rewrite several registers, clear protect and then request an update, and the whole group lands on one frame boundary. Writing the update-request register arms every window. Each armed window copies at the first vsync that finds it unprotected, and is then disarmed. A pending flag stays high while any window is still armed.

Every window has a control word, whose bit 0 is the window enable, and a geometry word. Windows from index 1 upward also carry a key control word and a key value word. Window 0 has no key storage.

Top module: `win_shadow_bank`

## Requirements
- R1: After reset, all shadow words, all window enables, the protect bits and `updPending` are zero.
- R2: A write to an active register leaves the shadow outputs unchanged in every cycle where `vsync` is low.
- R3: A write to address 1 with data bit 0 set arms every window, and `updPending` is high from the next cycle. At the next vsync, each armed window whose protect bit is clear copies its active words to the shadow outputs. The new values are visible in the cycle after the vsync edge.
- R4: A vsync that finds no window armed leaves every shadow output unchanged.
- R5: Address 0 holds one protect bit per window, with bit w for window w. A protected window is not copied at vsync and stays armed. It copies at the first vsync after its protect bit is cleared.
- R6: Bit 0 of a window's control word is its enable. Setting or clearing it changes `winEn` only when that window is copied at a vsync.
- R7: Window w's registers sit at address 2+4w+r, where r is 0 for control, 1 for geometry, 2 for key control and 3 for key value. Writes to the key addresses of window 0 are ignored, and window 0's key outputs always read zero.
- R8: A register write in the same cycle as vsync is not part of that vsync's copy. It lands at a later vsync. An update request written in the vsync cycle arms the windows for the next vsync.
- R9: `updPending` is high exactly while at least one window is armed. It falls only in the cycle after a vsync.
- R10: Writes to addresses at or above 2+4·NUM_WIN change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | One-cycle frame boundary pulse |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| winEn | output | NUM_WIN | Shadow window enables |
| shCtrl | output | NUM_WIN*DATA_W | Shadow control words, window w at slice w |
| shGeom | output | NUM_WIN*DATA_W | Shadow geometry words |
| shKeyCtl | output | NUM_WIN*DATA_W | Shadow key control words (zero for window 0) |
| shKeyVal | output | NUM_WIN*DATA_W | Shadow key value words (zero for window 0) |
| updPending | output | 1 | Update requested and not yet applied to every window |

## Verification
The bench builds the bank with NUM_WIN=3 and DATA_W=16. The third window gives a second keyed window, so a case where one keyed window is protected while another copies can occur. With this size the 4-bit address space also has two unmapped addresses, 14 and 15, which lets the bench exercise the ignored-write rule. Random protect masks, update requests and vsync pulses produce windows that stay armed across several frames. Directed cases place register writes and update requests in the same cycle as vsync.

// File: rtl/shbank_pkg.sv
package shbank_pkg;
  localparam int WIN_MAX      = 8;
  localparam int WIN_IDX_W    = $clog2(WIN_MAX);
  localparam int REGS_PER_WIN = 4;
  localparam int REG_IDX_W    = $clog2(REGS_PER_WIN);

  typedef enum logic [REG_IDX_W-1:0] {
    RG_CTRL   = 2'd0,
    RG_GEOM   = 2'd1,
    RG_KEYCTL = 2'd2,
    RG_KEYVAL = 2'd3
  } winReg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrValid;
    logic [WIN_IDX_W-1:0] wrWin;
    winReg_e              wrReg;
    logic [WIN_MAX-1:0]   copyMask;
  } bankStrobe_t;
endpackage

// File: rtl/shbank_ctrl.sv
module shbank_ctrl
  import shbank_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               vsync,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_WIN-1:0] wrLow,
  output bankStrobe_t        strobe,
  output logic               updPending
);
  localparam int FIRST_WIN_ADDR = 2;
  localparam int LAST_WIN_ADDR  = FIRST_WIN_ADDR + NUM_WIN * REGS_PER_WIN - 1;

  logic [NUM_WIN-1:0] protQ;
  logic [NUM_WIN-1:0] armQ;
  logic [NUM_WIN-1:0] copyNow;
  logic               protWr;
  logic               trigWr;
  int                 offs;

  assign protWr = wrEn && (wrAddr == ADDR_W'(0));
  assign trigWr = wrEn && (wrAddr == ADDR_W'(1)) && wrLow[0];

  always_comb begin
    offs           = int'(wrAddr) - FIRST_WIN_ADDR;
    strobe         = '0;
    strobe.wrValid = wrEn && (int'(wrAddr) >= FIRST_WIN_ADDR) &&
                     (int'(wrAddr) <= LAST_WIN_ADDR);
    strobe.wrWin   = WIN_IDX_W'(offs / REGS_PER_WIN);
    strobe.wrReg   = winReg_e'(REG_IDX_W'(offs % REGS_PER_WIN));
    strobe.copyMask[NUM_WIN-1:0] = copyNow;
  end

  assign copyNow    = vsync ? (armQ & ~protQ) : '0;
  assign updPending = |armQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protQ <= '0;
      armQ  <= '0;
    end else begin
      if (protWr) protQ <= wrLow;
      armQ <= trigWr ? '1 : (armQ & ~copyNow);
    end
  end
endmodule

// File: rtl/shbank_dp.sv
module shbank_dp
  import shbank_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bankStrobe_t               strobe,
  input  logic [DATA_W-1:0]         wrData,
  output logic [NUM_WIN-1:0]        winEn,
  output logic [NUM_WIN*DATA_W-1:0] shCtrl,
  output logic [NUM_WIN*DATA_W-1:0] shGeom,
  output logic [NUM_WIN*DATA_W-1:0] shKeyCtl,
  output logic [NUM_WIN*DATA_W-1:0] shKeyVal
);
  localparam int WORDS = NUM_WIN * REGS_PER_WIN;

  logic [WORDS*DATA_W-1:0] shFlat;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    for (genvar r = 0; r < REGS_PER_WIN; r++) begin : g_reg
      localparam int SLOT = (w * REGS_PER_WIN + r) * DATA_W;
      if (w == 0 && r >= int'(RG_KEYCTL)) begin : g_none
        assign shFlat[SLOT +: DATA_W] = '0;
      end else begin : g_store
        logic [DATA_W-1:0] actQ;
        logic [DATA_W-1:0] shQ;
        logic              hit;
        assign hit = strobe.wrValid && (strobe.wrWin == WIN_IDX_W'(w)) &&
                     (strobe.wrReg == winReg_e'(REG_IDX_W'(r)));
        always_ff @(posedge clk) begin
          if (!rstN) begin
            actQ <= '0;
            shQ  <= '0;
          end else begin
            if (strobe.copyMask[w]) shQ <= actQ;
            if (hit) actQ <= wrData;
          end
        end
        assign shFlat[SLOT +: DATA_W] = shQ;
      end
    end
    localparam int BASE = w * REGS_PER_WIN * DATA_W;
    assign shCtrl[w*DATA_W +: DATA_W]   = shFlat[BASE + 0*DATA_W +: DATA_W];
    assign shGeom[w*DATA_W +: DATA_W]   = shFlat[BASE + 1*DATA_W +: DATA_W];
    assign shKeyCtl[w*DATA_W +: DATA_W] = shFlat[BASE + 2*DATA_W +: DATA_W];
    assign shKeyVal[w*DATA_W +: DATA_W] = shFlat[BASE + 3*DATA_W +: DATA_W];
    assign winEn[w] = shFlat[BASE];
  end
endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank
  import shbank_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = $clog2(2 + NUM_WIN * REGS_PER_WIN)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      vsync,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [DATA_W-1:0]         wrData,
  output logic [NUM_WIN-1:0]        winEn,
  output logic [NUM_WIN*DATA_W-1:0] shCtrl,
  output logic [NUM_WIN*DATA_W-1:0] shGeom,
  output logic [NUM_WIN*DATA_W-1:0] shKeyCtl,
  output logic [NUM_WIN*DATA_W-1:0] shKeyVal,
  output logic                      updPending
);
  bankStrobe_t strobe;

  shbank_ctrl #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .vsync(vsync), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrLow(wrData[NUM_WIN-1:0]), .strobe(strobe), .updPending(updPending)
  );

  shbank_dp #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .winEn(winEn), .shCtrl(shCtrl), .shGeom(shGeom),
    .shKeyCtl(shKeyCtl), .shKeyVal(shKeyVal)
  );
endmodule

// File: rtl/win_shadow_bank_chk.sv
module win_shadow_bank_chk #(
  parameter int NUM_WIN = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      vsync,
  input logic                      wrEn,
  input logic [ADDR_W-1:0]         wrAddr,
  input logic [DATA_W-1:0]         wrData,
  input logic [NUM_WIN-1:0]        winEn,
  input logic [NUM_WIN*DATA_W-1:0] shCtrl,
  input logic [NUM_WIN*DATA_W-1:0] shGeom,
  input logic [NUM_WIN*DATA_W-1:0] shKeyCtl,
  input logic [NUM_WIN*DATA_W-1:0] shKeyVal,
  input logic                      updPending
);
  logic [4*NUM_WIN*DATA_W-1:0] shAll;
  assign shAll = {shCtrl, shGeom, shKeyCtl, shKeyVal};

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vsync |=> $stable(shAll));

  // R4
  noarm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vsync && !updPending) |=> $stable(shAll));

  // R6
  winen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vsync |=> $stable(winEn));

  // R3
  arm_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updPending) |-> $past(wrEn && wrAddr == ADDR_W'(1) && wrData[0]));

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(updPending) |-> $past(vsync));

  // R7
  win0_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shKeyCtl[DATA_W-1:0] == '0) && (shKeyVal[DATA_W-1:0] == '0));
endmodule

bind win_shadow_bank win_shadow_bank_chk #(
  .NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (.*);

// File: tb/test_win_shadow_bank.sv
module test_win_shadow_bank;
  localparam int NW = 3;
  localparam int DW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          vsync = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [NW-1:0] winEn;
  logic [NW*DW-1:0] shCtrl, shGeom, shKeyCtl, shKeyVal;
  logic          updPending;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [DW-1:0] mAct [NW][4];
  logic [DW-1:0] mSh  [NW][4];
  logic [NW-1:0] mProt;
  logic [NW-1:0] mPend;

  always #2.5 clk = ~clk;

  win_shadow_bank #(.NUM_WIN(NW), .DATA_W(DW), .ADDR_W(AW)) i_win_shadow_bank (
    .clk(clk), .rstN(rstN), .vsync(vsync), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .winEn(winEn), .shCtrl(shCtrl), .shGeom(shGeom),
    .shKeyCtl(shKeyCtl), .shKeyVal(shKeyVal), .updPending(updPending)
  );

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NW*DW-1:0] expWord(int r);
    logic [NW*DW-1:0] v;
    for (int w = 0; w < NW; w++) v[w*DW +: DW] = mSh[w][r];
    return v;
  endfunction

  function automatic logic [NW-1:0] expEn();
    logic [NW-1:0] v;
    for (int w = 0; w < NW; w++) v[w] = mSh[w][0][0];
    return v;
  endfunction

  task automatic modelReset();
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) begin
        mAct[w][r] = '0;
        mSh[w][r]  = '0;
      end
    mProt = '0;
    mPend = '0;
  endtask

  // next model state from the inputs applied in this cycle
  task automatic modelStep(bit we, int a, logic [DW-1:0] d, bit vs);
    for (int w = 0; w < NW; w++)
      if (vs && mPend[w] && !mProt[w]) begin
        for (int r = 0; r < 4; r++) mSh[w][r] = mAct[w][r];
        mPend[w] = 1'b0;
      end
    if (we) begin
      if (a == 0) mProt = d[NW-1:0];
      else if (a == 1) begin
        if (d[0]) mPend = '1;
      end else if (a < 2 + 4*NW) begin
        if (!((a - 2) / 4 == 0 && (a - 2) % 4 >= 2))
          mAct[(a - 2) / 4][(a - 2) % 4] = d;
      end
    end
  endtask

  task automatic checkAll(string tag);
    cmp({tag, " winEn"}, 64'(winEn), 64'(expEn()));
    cmp({tag, " shCtrl"}, 64'(shCtrl), 64'(expWord(0)));
    cmp({tag, " shGeom"}, 64'(shGeom), 64'(expWord(1)));
    cmp({tag, " shKeyCtl"}, 64'(shKeyCtl), 64'(expWord(2)));
    cmp({tag, " shKeyVal"}, 64'(shKeyVal), 64'(expWord(3)));
    cmp({tag, " updPending"}, 64'(updPending), 64'(|mPend));
  endtask

  // called at a negedge: drive, advance one cycle, check at the next negedge
  task automatic step(string tag, bit we, int a, logic [DW-1:0] d, bit vs);
    wrEn   = we;
    wrAddr = AW'(a);
    wrData = d;
    vsync  = vs;
    modelStep(we, a, d, vs);
    @(posedge clk);
    @(negedge clk);
    wrEn  = 1'b0;
    vsync = 1'b0;
    checkAll(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R1");

    // R2: active write without vsync or request
    step("R2", 1, 2, 16'h0001, 0);
    step("R4", 0, 0, 0, 1);
    cmp("R4 win0 still off", 64'(winEn[0]), 64'd0);
    // R3 and R6
    step("R3", 1, 1, 16'h0001, 0);
    cmp("R3 pending", 64'(updPending), 64'd1);
    step("R3", 0, 0, 0, 1);
    cmp("R6 win0 on", 64'(winEn[0]), 64'd1);
    cmp("R9 cleared", 64'(updPending), 64'd0);
    // R5: protected window holds and stays armed
    step("R5", 1, 0, 16'h0001, 0);
    step("R5", 1, 2, 16'h0000, 0);
    step("R5", 1, 1, 16'h0001, 0);
    step("R5", 0, 0, 0, 1);
    cmp("R5 win0 held", 64'(winEn[0]), 64'd1);
    cmp("R5 still pending", 64'(updPending), 64'd1);
    step("R5", 1, 0, 16'h0000, 0);
    step("R6", 0, 0, 0, 1);
    cmp("R6 win0 off at vsync", 64'(winEn[0]), 64'd0);
    // R7: window 0 key writes dropped, window 1 keys copy
    step("R7", 1, 4, 16'hBEEF, 0);
    step("R7", 1, 5, 16'hCAFE, 0);
    step("R7", 1, 8, 16'h1234, 0);
    step("R7", 1, 1, 16'h0001, 0);
    step("R7", 0, 0, 0, 1);
    cmp("R7 win0 key", 64'(shKeyCtl[DW-1:0]), 64'd0);
    cmp("R7 win1 key", 64'(shKeyCtl[2*DW-1:DW]), 64'h1234);
    // R8: write in vsync cycle goes to the next frame
    step("R8", 1, 1, 16'h0001, 0);
    step("R8", 1, 7, 16'h0055, 1);
    cmp("R8 geom old", 64'(shGeom[2*DW-1:DW]), 64'd0);
    step("R8", 1, 1, 16'h0001, 1);
    cmp("R8 req in vsync pending", 64'(updPending), 64'd1);
    step("R8", 0, 0, 0, 1);
    cmp("R8 geom new", 64'(shGeom[2*DW-1:DW]), 64'h0055);
    // R10: unmapped addresses
    step("R10", 1, 14, 16'hFFFF, 0);
    step("R10", 1, 15, 16'hFFFF, 0);
    step("R10", 1, 1, 16'h0001, 0);
    step("R10", 0, 0, 0, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom_range(0, 3) != 0);
      int a  = $urandom_range(0, 15);
      logic [DW-1:0] d = DW'($urandom);
      bit vs = ($urandom_range(0, 5) == 0);
      if (a == 0 && $urandom_range(0, 1) == 1) d = '0;
      step("R9 random", we, a, d, vs);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule